// File: doc/BRIEF.md
# Programmable External Wait-State Generator

This block stretches external memory accesses by a number of idle cycles that software sets per address region. Software writes two registers through a small register port. The first is a packed timing register. It holds five 3-bit base counts and an extended-addressing mode bit. The second is a control register whose only live bit doubles every base count.

Each external access arrives as a one-cycle strobe carrying a space code (program, data or I/O) and a 23-bit address. The block picks the base count for that region and doubles it when the multiplier is set. It then holds `acc_ready` low for that many cycles and raises it for one cycle to complete the access. While the countdown runs, `acc_busy` is high and further strobes are dropped. The block latches the count when the access starts, so a register write made during an access only affects accesses that start after it.

Top module: `wait_state_gen`

## Requirements
- R1: After reset the timing register (register address 0x28) reads 0x7FFF, meaning all five counts are 7 and the mode bit is 0. The control register (register address 0x29) reads 0x0000.
- R2: The timing register stores all 16 written bits and reads them back unchanged. Its layout is: bit 15 mode, bits 14:12 I/O count, 11:9 upper-data count, 8:6 lower-data count, 5:3 upper-program count, 2:0 lower-program count.
- R3: In the control register only bit 0 (multiplier) is writable. Bits 15:1 always read 0, and writing ones to them has no effect. Any other register address reads 0.
- R4: An access with space code 2 (I/O) uses the I/O count for any address, and address bits above 15 have no effect. Space code 3 also uses the I/O count.
- R5: An access with space code 1 (data) uses the upper-data count when address bit 15 is 1 and the lower-data count when it is 0. The mode bit and address bits above 15 have no effect.
- R6: An access with space code 0 (program) and the mode bit clear uses the upper-program count when address bit 15 is 1 and the lower-program count otherwise. Address bits 22:16 are ignored.
- R7: A program access with the mode bit set uses the upper-program count when address bit 22 is 1 and the lower-program count otherwise. Address bit 15 is ignored.
- R8: With the multiplier bit 0 the wait count equals the selected base count. With the multiplier bit 1 it is twice the base count, so the largest count is 14.
- R9: For a wait count N greater than 0, `acc_ready` is low in the request cycle and the N-1 cycles after it, then high for exactly one cycle. For N equal to 0, `acc_ready` is high in the request cycle itself.
- R10: `acc_busy` is high from the cycle after an accepted request up to and including its ready cycle. A request made while busy produces no ready and no extra busy cycles.
- R11: A register write takes effect only for accesses that start after the write. An access already counting keeps its latched count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on `reg_addr`) |
| acc_req | input | 1 | One-cycle access request strobe |
| acc_space | input | 2 | Space code: 0 program, 1 data, 2 I/O, 3 treated as I/O |
| acc_addr | input | 23 | Access address |
| acc_ready | output | 1 | Access completes in this cycle |
| acc_busy | output | 1 | Wait countdown in progress |

## Verification
The hardest case to reach is a register update that lands while a countdown is already running. Checking it needs a non-zero count in flight, a write issued in the middle of it, and then a second access to show that the new value arrived. The stimulus starts a long I/O access and rewrites the I/O field two cycles into the wait. It then measures the remaining wait and a fresh I/O access. A dropped request during busy is reached the same way, by pulsing the strobe halfway through a countdown. The bench then checks that neither the ready count nor the busy window changes.

// File: rtl/ws_pkg.sv
`timescale 1ns/1ps
package ws_pkg;

  typedef enum logic [1:0] {
    SP_PROG = 2'd0,
    SP_DATA = 2'd1,
    SP_IO   = 2'd2,
    SP_RSVD = 2'd3
  } space_e;

  // Field slots inside the timing register, lowest first.
  localparam int NUM_FIELDS = 5;
  localparam int F_PLO = 0;
  localparam int F_PHI = 1;
  localparam int F_DLO = 2;
  localparam int F_DHI = 3;
  localparam int F_IO  = 4;

endpackage

// File: rtl/ws_regs.sv
`timescale 1ns/1ps
module ws_regs #(
  parameter int          REG_W    = 16,
  parameter int          CNT_W    = 3,
  parameter int          RA_W     = 8,
  parameter logic [7:0]  WSR_ADDR = 8'h28,
  parameter logic [7:0]  CTL_ADDR = 8'h29
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       we,
  input  logic [RA_W-1:0]                            addr,
  input  logic [REG_W-1:0]                           wdata,
  output logic [REG_W-1:0]                           rdata,
  output logic [ws_pkg::NUM_FIELDS-1:0][CNT_W-1:0]   fields,
  output logic                                       xmode,
  output logic                                       mult
);
  import ws_pkg::*;

  localparam int XBIT = REG_W - 1;
  localparam logic [REG_W-1:0] WSR_RST = {1'b0, {(REG_W-1){1'b1}}};

  logic [REG_W-1:0] wsr_q, wsr_d;
  logic             mult_q, mult_d;
  logic             wsr_hit, ctl_hit;
  logic             wsr_en, ctl_en;

  assign wsr_hit = (addr == WSR_ADDR[RA_W-1:0]);
  assign ctl_hit = (addr == CTL_ADDR[RA_W-1:0]);
  assign wsr_en  = we & wsr_hit;
  assign ctl_en  = we & ctl_hit;

  always_comb begin
    wsr_d  = wdata;
    mult_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsr_q <= WSR_RST;
    end else if (wsr_en) begin
      wsr_q <= wsr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q <= 1'b0;
    end else if (ctl_en) begin
      mult_q <= mult_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (wsr_hit) begin
      rdata = wsr_q;
    end else if (ctl_hit) begin
      rdata[0] = mult_q;
    end
  end

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
    assign fields[gi] = wsr_q[gi*CNT_W +: CNT_W];
  end

  assign xmode = wsr_q[XBIT];
  assign mult  = mult_q;

endmodule

// File: rtl/ws_region_sel.sv
`timescale 1ns/1ps
module ws_region_sel #(
  parameter int ADDR_W   = 23,
  parameter int CNT_W    = 3,
  parameter int PAGE_BIT = 15
) (
  input  logic [1:0]                                 space,
  input  logic [ADDR_W-1:0]                          addr,
  input  logic                                       xmode,
  input  logic [ws_pkg::NUM_FIELDS-1:0][CNT_W-1:0]   fields,
  output logic [CNT_W-1:0]                           base
);
  import ws_pkg::*;

  localparam int EXT_BIT = ADDR_W - 1;

  logic prog_hi;
  logic half_hi;
  logic unused_addr_bits;

  assign half_hi = addr[PAGE_BIT];
  assign prog_hi = xmode ? addr[EXT_BIT] : addr[PAGE_BIT];
  assign unused_addr_bits = ^{addr[EXT_BIT-1:PAGE_BIT+1], addr[PAGE_BIT-1:0]};

  always_comb begin
    unique case (space_e'(space))
      SP_PROG: base = prog_hi ? fields[F_PHI] : fields[F_PLO];
      SP_DATA: base = half_hi ? fields[F_DHI] : fields[F_DLO];
      default: base = fields[F_IO];
    endcase
  end

endmodule

// File: rtl/ws_scale.sv
`timescale 1ns/1ps
module ws_scale #(
  parameter int CNT_W = 3
) (
  input  logic [CNT_W-1:0] base,
  input  logic             mult,
  output logic [CNT_W:0]   count
);
  always_comb begin
    if (mult) begin
      count = {base, 1'b0};
    end else begin
      count = {1'b0, base};
    end
  end
endmodule

// File: rtl/ws_counter.sv
`timescale 1ns/1ps
module ws_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [W-1:0] count,
  output logic         ready,
  output logic         busy
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         start, cnt_en, zero_req;

  assign busy     = (cnt_q != '0);
  assign start    = req & ~busy;
  assign zero_req = start & (count == '0);
  assign cnt_en   = start | busy;

  always_comb begin
    if (start) begin
      cnt_d = count;
    end else begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ready = zero_req | (cnt_q == ONE);

endmodule

// File: rtl/wait_state_gen.sv
`timescale 1ns/1ps
module wait_state_gen #(
  parameter int          ADDR_W   = 23,
  parameter int          REG_W    = 16,
  parameter int          CNT_W    = 3,
  parameter int          RA_W     = 8,
  parameter int          PAGE_BIT = 15,
  parameter logic [7:0]  WSR_ADDR = 8'h28,
  parameter logic [7:0]  CTL_ADDR = 8'h29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              acc_req,
  input  logic [1:0]        acc_space,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              acc_ready,
  output logic              acc_busy
);
  import ws_pkg::*;

  localparam int TOT_W = CNT_W + 1;

  logic [NUM_FIELDS-1:0][CNT_W-1:0] fields;
  logic                             xmode;
  logic                             mult;
  logic [CNT_W-1:0]                 base;
  logic [TOT_W-1:0]                 count;

  ws_regs #(
    .REG_W(REG_W), .CNT_W(CNT_W), .RA_W(RA_W),
    .WSR_ADDR(WSR_ADDR), .CTL_ADDR(CTL_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .fields(fields),
    .xmode(xmode), .mult(mult)
  );

  ws_region_sel #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_BIT(PAGE_BIT)
  ) u_sel (
    .space(acc_space), .addr(acc_addr), .xmode(xmode),
    .fields(fields), .base(base)
  );

  ws_scale #(.CNT_W(CNT_W)) u_scale (
    .base(base), .mult(mult), .count(count)
  );

  ws_counter #(.W(TOT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .req(acc_req), .count(count),
    .ready(acc_ready), .busy(acc_busy)
  );

endmodule

// File: rtl/ws_chk.sv
`timescale 1ns/1ps
module ws_chk #(
  parameter int          ADDR_W   = 23,
  parameter int          REG_W    = 16,
  parameter int          CNT_W    = 3,
  parameter int          RA_W     = 8,
  parameter logic [7:0]  CTL_ADDR = 8'h29
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [RA_W-1:0]   reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              acc_req,
  input logic [1:0]        acc_space,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_ready,
  input logic              acc_busy
);
  localparam int MAXW  = 2 * ((1 << CNT_W) - 1);
  localparam int RUN_W = CNT_W + 2;

  logic [RUN_W-1:0] run_q;
  logic             unused_chk;

  assign unused_chk = ^{reg_we, reg_wdata, acc_space, acc_addr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (acc_busy) begin
      if (run_q != '1) run_q <= run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  // R8: no countdown lasts longer than twice the largest base count
  p_max_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_q) <= MAXW);

  // R9: ready outside a countdown only with a same-cycle request
  p_idle_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ready && !acc_busy) |-> acc_req);

  // R9: busy without ready keeps counting
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_busy && !acc_ready) |=> acc_busy);

  // R10: the ready cycle ends the countdown
  p_busy_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_busy && acc_ready) |=> !acc_busy);

  // R10: a countdown only begins after a request
  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_busy) |-> $past(acc_req));

  // R3: reserved control bits read as zero
  p_ctl_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CTL_ADDR[RA_W-1:0]) |-> (reg_rdata[REG_W-1:1] == '0));

endmodule

bind wait_state_gen ws_chk #(
  .ADDR_W(ADDR_W), .REG_W(REG_W), .CNT_W(CNT_W), .RA_W(RA_W), .CTL_ADDR(CTL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_req(acc_req),
  .acc_space(acc_space), .acc_addr(acc_addr), .acc_ready(acc_ready),
  .acc_busy(acc_busy)
);

// File: tb/wait_state_gen_test.sv
`timescale 1ns/1ps
module wait_state_gen_test;

  localparam logic [7:0]  A_WSR = 8'h28;
  localparam logic [7:0]  A_CTL = 8'h29;
  localparam logic [15:0] PAT   = 16'h58D1; // io5 ud4 ld3 up2 lp1
  localparam int          NV    = 15;

  // {space[30:29], addr[28:6], xmode[5], mult[4], expected[3:0]}
  localparam logic [30:0] VEC [NV] = '{
    {2'd2, 23'h000000, 1'b0, 1'b0, 4'd5},   // R4
    {2'd2, 23'h7FFFFF, 1'b0, 1'b0, 4'd5},   // R4 upper bits ignored
    {2'd1, 23'h008000, 1'b0, 1'b0, 4'd4},   // R5
    {2'd1, 23'h007FFF, 1'b0, 1'b0, 4'd3},   // R5
    {2'd1, 23'h408000, 1'b1, 1'b0, 4'd4},   // R5 mode ignored
    {2'd0, 23'h000000, 1'b0, 1'b0, 4'd1},   // R6
    {2'd0, 23'h00FFFF, 1'b0, 1'b0, 4'd2},   // R6
    {2'd0, 23'h7F7FFF, 1'b0, 1'b0, 4'd1},   // R6 page ignored
    {2'd0, 23'h400000, 1'b1, 1'b0, 4'd2},   // R7
    {2'd0, 23'h3FFFFF, 1'b1, 1'b0, 4'd1},   // R7
    {2'd0, 23'h008000, 1'b1, 1'b0, 4'd1},   // R7 bit 15 ignored
    {2'd0, 23'h407FFF, 1'b1, 1'b0, 4'd2},   // R7
    {2'd3, 23'h001234, 1'b0, 1'b1, 4'd10},  // R4 R8
    {2'd1, 23'h008000, 1'b0, 1'b1, 4'd8},   // R8
    {2'd0, 23'h000000, 1'b0, 1'b1, 4'd2}    // R8
  };

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        acc_req;
  logic [1:0]  acc_space;
  logic [22:0] acc_addr;
  logic        acc_ready;
  logic        acc_busy;

  int n_run  = 0;
  int n_fail = 0;

  wait_state_gen uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_req(acc_req),
    .acc_space(acc_space), .acc_addr(acc_addr), .acc_ready(acc_ready),
    .acc_busy(acc_busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0d (0x%0h) exp=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // Measures cycles of low ready from the request cycle; optional
  // injection of a request or a timing-register write at wait 2.
  task automatic access(input logic [1:0] sp, input logic [22:0] ad,
                        input bit inj_req, input bit inj_wr,
                        input logic [15:0] inj_d,
                        output int waits, output bit busy_ok);
    busy_ok = 1'b1;
    waits   = 0;
    @(negedge clk);
    acc_space = sp; acc_addr = ad; acc_req = 1'b1;
    #1;
    if (acc_busy) busy_ok = 1'b0;
    if (!acc_ready) begin
      forever begin
        @(negedge clk);
        acc_req = 1'b0; reg_we = 1'b0;
        waits++;
        #1;
        if (!acc_busy) busy_ok = 1'b0;
        if (acc_ready || waits > 40) break;
        if (waits == 2) begin
          if (inj_req) begin
            acc_req = 1'b1; acc_space = 2'd1; acc_addr = 23'h0;
          end
          if (inj_wr) begin
            reg_we = 1'b1; reg_addr = A_WSR; reg_wdata = inj_d;
          end
        end
      end
    end
    @(negedge clk);
    acc_req = 1'b0; reg_we = 1'b0;
    #1;
    if (acc_busy || acc_ready) busy_ok = 1'b0;
  endtask

  initial begin
    logic [15:0] d;
    int          w;
    bit          ok;

    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    acc_req = 1'b0; acc_space = '0; acc_addr = '0;
    #1;
    check("R10 busy in reset", int'(acc_busy), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(A_WSR, d); check("R1 timing reset", int'(d), 16'h7FFF);
    rd(A_CTL, d); check("R1 control reset", int'(d), 0);
    access(2'd2, 23'h0, 1'b0, 1'b0, 16'h0, w, ok);
    check("R1 reset wait count", w, 7);
    check("R10 busy window", int'(ok), 1);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      wr(A_WSR, PAT | {v[5], 15'h0});
      wr(A_CTL, {15'h0, v[4]});
      access(v[30:29], v[28:6], 1'b0, 1'b0, 16'h0, w, ok);
      check($sformatf("R4-7 R8 R9 vector %0d", i), w, int'(v[3:0]));
      check($sformatf("R10 busy vector %0d", i), int'(ok), 1);
    end

    // R2 readback
    wr(A_WSR, 16'hA5C3); rd(A_WSR, d); check("R2 readback", int'(d), 16'hA5C3);

    // R3 reserved bits
    wr(A_CTL, 16'hFFFE); rd(A_CTL, d); check("R3 reserved ignored", int'(d), 0);
    wr(A_CTL, 16'hFFFF); rd(A_CTL, d); check("R3 only bit0", int'(d), 1);
    rd(8'h33, d); check("R3 unmapped read", int'(d), 0);

    // R8 maximum
    wr(A_WSR, 16'h7FFF);
    access(2'd1, 23'h0, 1'b0, 1'b0, 16'h0, w, ok);
    check("R8 max doubled", w, 14);
    check("R10 busy max", int'(ok), 1);

    // R9 zero count
    wr(A_CTL, 16'h0); wr(A_WSR, 16'h0);
    access(2'd0, 23'h0, 1'b0, 1'b0, 16'h0, w, ok);
    check("R9 zero wait", w, 0);
    check("R9 zero no busy", int'(ok), 1);
    access(2'd0, 23'h0, 1'b0, 1'b0, 16'h0, w, ok);
    check("R9 zero repeat", w, 0);

    // R10 request during busy ignored
    wr(A_WSR, 16'h5000 | 16'h0200); // io5, ld... data lo = 0? keep data hi 1
    access(2'd2, 23'h0, 1'b1, 1'b0, 16'h0, w, ok);
    check("R10 ignored request wait", w, 5);
    check("R10 no extra busy", int'(ok), 1);

    // R11 write during countdown
    wr(A_WSR, 16'h5000);
    access(2'd2, 23'h0, 1'b0, 1'b1, 16'h1000, w, ok);
    check("R11 in-flight unchanged", w, 5);
    access(2'd2, 23'h0, 1'b0, 1'b0, 16'h0, w, ok);
    check("R11 next access new", w, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule